// File: doc/BRIEF.md
# Preamble pattern qualifier

This block sits behind a bit slicer and decides whether the incoming serial stream carries a valid preamble. A bit is taken from `bit_in` in every clock cycle where `bit_vld` is high. The block counts consecutive alternating 0-then-1 pairs. When the count reaches the programmed threshold `pair_thr`, it declares a qualified preamble. A threshold of twelve pairs, for example, needs three bytes of `0101...` pattern.

On qualification it issues a one-cycle detect pulse. It can also raise a maskable interrupt request and one-cycle lock strobes for the frequency-correction loop and the gain loop. It then keeps following the alternating pattern. On the first bit that breaks the pattern it flags the end of the preamble, which hands control to a downstream sync word searcher.

The block stays idle until that searcher reports a sync timeout. The timeout re-arms the pair counting from a cleared state. Writing zero into `pair_thr` turns detection off.

Top module: `preamble_qualifier`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pre_det`, `pre_irq`, `freq_lock`, `gain_lock` and `pre_end` are all 0.
- R2: A pair is counted when an accepted 0 bit is followed by an accepted 1 bit. When the pair count reaches `pair_thr`, `pre_det` is high for the cycle after the clock edge that accepted the completing 1 bit.
- R3: Two equal consecutive accepted bits reset the pair count to zero. Counting then restarts with the next 0-to-1 pair.
- R4: With `pair_thr` equal to 0, `pre_det` never rises, whatever the stream.
- R5: `pre_irq` is high exactly when `pre_det` is high and `pd_irq_en` was 1 at the qualifying bit.
- R6: `freq_lock` and `gain_lock` pulse together with `pre_det`, each only if `freq_lock_en` or `gain_lock_en` respectively was 1 at the qualifying bit.
- R7: `pre_det` and the lock strobes are one cycle wide. `pre_det` fires only once per preamble, even if the alternation goes on past the threshold.
- R8: After qualification, the first accepted bit equal to its predecessor makes `pre_end` high for one cycle, in the cycle after that bit's edge.
- R9: After `pre_end`, no detection occurs until `sync_timeout` is seen high. The timeout clears the pair count and the bit history. A `sync_timeout` while still hunting, before any qualification, has no effect.
- R10: Cycles with `bit_vld` low change neither the pair count nor the bit history, whatever `bit_in` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Recovered bit strobe, one accepted bit per high cycle |
| bit_in | input | 1 | Recovered data bit |
| pair_thr | input | CNT_W (8) | Number of 0-1 pairs required; 0 disables detection |
| pd_irq_en | input | 1 | Enables the detect interrupt request |
| freq_lock_en | input | 1 | Enables the frequency-loop lock strobe |
| gain_lock_en | input | 1 | Enables the gain-loop lock strobe |
| sync_timeout | input | 1 | Downstream sync search gave up; re-arms the block |
| pre_det | output | 1 | One-cycle qualified-preamble pulse |
| pre_irq | output | 1 | Masked interrupt request, one cycle |
| freq_lock | output | 1 | One-cycle lock strobe for the frequency loop |
| gain_lock | output | 1 | One-cycle lock strobe for the gain loop |
| pre_end | output | 1 | One-cycle end-of-preamble pulse for the sync searcher |

## Verification
Every output is registered once. It is therefore due one clock edge after the edge that accepts the bit that causes it: the completing 1 bit for `pre_det`, `pre_irq` and the lock strobes, and the repeated bit for `pre_end`. The bench drives each bit on a falling edge and samples all five outputs 1 ns after the next rising edge. It compares them against the bit index that the vector table names as the detect or end point, so a pulse that comes one cycle early, late or too wide is caught. The re-arm and idle-strobe cases are checked the same way. In those cases the effect of the earlier stimulus shows up as when the following detect pulse lands.

// File: rtl/pq_pkg.sv
package pq_pkg;

  typedef enum logic [1:0] {
    PQ_HUNT    = 2'd0,
    PQ_TRACK   = 2'd1,
    PQ_HANDOFF = 2'd2
  } pq_state_e;

  // a 0 bit followed by a 1 bit completes one pair
  function automatic logic pq_is_pair(input logic have_prev, input logic prev_bit,
                                      input logic cur_bit);
    return have_prev && !prev_bit && cur_bit;
  endfunction

  // two equal bits in a row break the alternating pattern
  function automatic logic pq_is_break(input logic have_prev, input logic prev_bit,
                                       input logic cur_bit);
    return have_prev && (prev_bit == cur_bit);
  endfunction

endpackage

// File: rtl/pq_pair_counter.sv
module pq_pair_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt_next,
  output logic             pair_evt,
  output logic             break_evt
);
  import pq_pkg::*;

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             have_prev;
  logic             prev_bit;
  logic [CNT_W-1:0] pair_cnt;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + CNT_ONE;
  endfunction

  always_comb begin
    pair_evt  = bit_vld && pq_is_pair(have_prev, prev_bit, bit_in);
    break_evt = bit_vld && pq_is_break(have_prev, prev_bit, bit_in);
    if (break_evt)     cnt_next = '0;
    else if (pair_evt) cnt_next = sat_inc(pair_cnt);
    else               cnt_next = pair_cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      have_prev <= 1'b0;
      prev_bit  <= 1'b0;
      pair_cnt  <= '0;
    end else if (bit_vld) begin
      have_prev <= 1'b1;
      prev_bit  <= bit_in;
      pair_cnt  <= cnt_next;
    end
  end

  // R3: a broken pattern leaves the counter empty
  p_break_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (break_evt && !clear) |=> (pair_cnt == '0));

  // R10: idle strobes leave count and history alone
  p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld && !clear) |=> ($stable(pair_cnt) && $stable(prev_bit) && $stable(have_prev)));

  // R9: a re-arm wipes the history
  p_clear_wipes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!have_prev && pair_cnt == '0));

endmodule

// File: rtl/pq_ctrl.sv
module pq_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pair_evt,
  input  logic               break_evt,
  input  logic [CNT_W-1:0]   cnt_next,
  input  logic [CNT_W-1:0]   pair_thr,
  input  logic               sync_timeout,
  output pq_pkg::pq_state_e  state,
  output logic               det_evt,
  output logic               end_evt,
  output logic               rearm
);
  import pq_pkg::*;

  pq_state_e state_nx;

  // threshold zero means detection is switched off
  function automatic logic thr_reached(input logic [CNT_W-1:0] cnt,
                                       input logic [CNT_W-1:0] thr);
    return (thr != '0) && (cnt >= thr);
  endfunction

  always_comb begin
    det_evt  = (state == PQ_HUNT) && pair_evt && thr_reached(cnt_next, pair_thr);
    end_evt  = (state == PQ_TRACK) && break_evt;
    rearm    = (state == PQ_HANDOFF) && sync_timeout;
    state_nx = state;
    unique case (state)
      PQ_HUNT:    if (det_evt) state_nx = PQ_TRACK;
      PQ_TRACK:   if (end_evt) state_nx = PQ_HANDOFF;
      PQ_HANDOFF: if (rearm)   state_nx = PQ_HUNT;
      default:    state_nx = PQ_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= PQ_HUNT;
    else        state <= state_nx;
  end

  // R8: an end event always hands over
  p_end_hands_over_r8: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> (state == PQ_HANDOFF));

  // R9: handoff is left only through a sync timeout
  p_handoff_waits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PQ_HANDOFF && !sync_timeout) |=> (state == PQ_HANDOFF));

  // R7: a detection moves on to tracking, so it cannot repeat at once
  p_det_leaves_hunt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    det_evt |=> (state == PQ_TRACK));

endmodule

// File: rtl/pq_event_out.sv
module pq_event_out (
  input  logic clk,
  input  logic rst_n,
  input  logic det_evt,
  input  logic end_evt,
  input  logic irq_en,
  input  logic freq_en,
  input  logic gain_en,
  output logic det_o,
  output logic irq_o,
  output logic freq_o,
  output logic gain_o,
  output logic end_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      det_o  <= 1'b0;
      irq_o  <= 1'b0;
      freq_o <= 1'b0;
      gain_o <= 1'b0;
      end_o  <= 1'b0;
    end else begin
      det_o  <= det_evt;
      irq_o  <= det_evt && irq_en;
      freq_o <= det_evt && freq_en;
      gain_o <= det_evt && gain_en;
      end_o  <= end_evt;
    end
  end

  // R5: no interrupt without a detection
  p_irq_needs_det_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> det_o);

  // R6: lock strobes ride on the detect pulse
  p_lock_needs_det_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_o || gain_o) |-> det_o);

  // R7: detect and locks are single-cycle
  p_det_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    det_o |=> !det_o);

  // R8: end of preamble is single-cycle
  p_end_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |=> !end_o);

endmodule

// File: rtl/preamble_qualifier.sv
module preamble_qualifier #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic [CNT_W-1:0] pair_thr,
  input  logic             pd_irq_en,
  input  logic             freq_lock_en,
  input  logic             gain_lock_en,
  input  logic             sync_timeout,
  output logic             pre_det,
  output logic             pre_irq,
  output logic             freq_lock,
  output logic             gain_lock,
  output logic             pre_end
);
  import pq_pkg::*;

  logic [CNT_W-1:0] cnt_next;
  logic             pair_evt;
  logic             break_evt;
  logic             det_evt;
  logic             end_evt;
  logic             rearm;
  pq_state_e        state;

  pq_pair_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_vld   (bit_vld),
    .bit_in    (bit_in),
    .clear     (rearm),
    .cnt_next  (cnt_next),
    .pair_evt  (pair_evt),
    .break_evt (break_evt)
  );

  pq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .pair_evt     (pair_evt),
    .break_evt    (break_evt),
    .cnt_next     (cnt_next),
    .pair_thr     (pair_thr),
    .sync_timeout (sync_timeout),
    .state        (state),
    .det_evt      (det_evt),
    .end_evt      (end_evt),
    .rearm        (rearm)
  );

  pq_event_out u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .det_evt (det_evt),
    .end_evt (end_evt),
    .irq_en  (pd_irq_en),
    .freq_en (freq_lock_en),
    .gain_en (gain_lock_en),
    .det_o   (pre_det),
    .irq_o   (pre_irq),
    .freq_o  (freq_lock),
    .gain_o  (gain_lock),
    .end_o   (pre_end)
  );

  // R4: a zero threshold never yields a detect pulse
  p_zero_thr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_thr == '0) |=> !pre_det);

  // R9: while handing off, no new detection appears
  p_quiet_handoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PQ_HANDOFF) |=> !pre_det);

endmodule

// File: tb/preamble_qualifier_bench.sv
module preamble_qualifier_bench;

  typedef struct packed {
    logic [7:0]  thr;
    logic [31:0] bits;    // bit i is sent i-th
    logic [5:0]  len;
    logic [7:0]  det_at;  // index of the bit whose edge raises pre_det; 255 = never
    logic [7:0]  end_at;  // index of the bit whose edge raises pre_end; 255 = never
    logic        irq_en;
    logic        f_en;
    logic        g_en;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'd2,  32'h0000004A, 6'd8,  8'd3,   8'd5,   1'b1, 1'b1, 1'b0},
    '{8'd3,  32'h00000356, 6'd10, 8'd8,   8'd9,   1'b0, 1'b0, 1'b1},
    '{8'd0,  32'hAAAAAAAA, 6'd32, 8'd255, 8'd255, 1'b1, 1'b1, 1'b1},
    '{8'd12, 32'hAAAAAAAA, 6'd32, 8'd23,  8'd255, 1'b1, 1'b0, 1'b1},
    '{8'd1,  32'h00000037, 6'd6,  8'd4,   8'd5,   1'b1, 1'b1, 1'b1},
    '{8'd4,  32'h00000155, 6'd11, 8'd8,   8'd10,  1'b0, 1'b1, 1'b0},
    '{8'd5,  32'h000005AA, 6'd11, 8'd255, 8'd255, 1'b1, 1'b1, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_vld = 1'b0;
  logic       bit_in = 1'b0;
  logic [7:0] pair_thr = 8'd0;
  logic       pd_irq_en = 1'b0;
  logic       freq_lock_en = 1'b0;
  logic       gain_lock_en = 1'b0;
  logic       sync_timeout = 1'b0;
  logic       pre_det, pre_irq, freq_lock, gain_lock, pre_end;

  int  n_tests = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  preamble_qualifier u_preamble_qualifier (
    .clk, .rst_n, .bit_vld, .bit_in, .pair_thr, .pd_irq_en, .freq_lock_en,
    .gain_lock_en, .sync_timeout, .pre_det, .pre_irq, .freq_lock, .gain_lock, .pre_end
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_vld = 1'b1;
    bit_in  = b;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n, input logic b);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bit_vld = 1'b0;
      bit_in  = b;
      @(posedge clk);
      #1;
    end
  endtask

  task automatic pulse_timeout();
    @(negedge clk);
    bit_vld = 1'b0;
    sync_timeout = 1'b1;
    @(posedge clk);
    #1;
    @(negedge clk);
    sync_timeout = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bit_vld = 1'b0;
    sync_timeout = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_all_low(input string req);
    check(req, "pre_det",   pre_det,   0);
    check(req, "pre_irq",   pre_irq,   0);
    check(req, "freq_lock", freq_lock, 0);
    check(req, "gain_lock", gain_lock, 0);
    check(req, "pre_end",   pre_end,   0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check_all_low("R1");
    do_reset();
    @(posedge clk);
    #1;
    check_all_low("R1");

    // vector table: R2, R3, R4, R5, R6, R7, R8
    for (int v = 0; v < NV; v++) begin
      do_reset();
      pair_thr     = VECS[v].thr;
      pd_irq_en    = VECS[v].irq_en;
      freq_lock_en = VECS[v].f_en;
      gain_lock_en = VECS[v].g_en;
      for (int i = 0; i < int'(VECS[v].len); i++) begin
        logic hit;
        send_bit(VECS[v].bits[i]);
        hit = (i == int'(VECS[v].det_at));
        check((VECS[v].thr == 0) ? "R4" : "R2/R3", $sformatf("v%0d bit%0d pre_det", v, i),
              pre_det, hit);
        check("R5", $sformatf("v%0d bit%0d pre_irq", v, i), pre_irq, hit && VECS[v].irq_en);
        check("R6", $sformatf("v%0d bit%0d freq_lock", v, i), freq_lock, hit && VECS[v].f_en);
        check("R6", $sformatf("v%0d bit%0d gain_lock", v, i), gain_lock, hit && VECS[v].g_en);
        check("R8", $sformatf("v%0d bit%0d pre_end", v, i), pre_end,
              i == int'(VECS[v].end_at));
      end
      idle(1, 1'b0);
      check("R7", $sformatf("v%0d trailing pre_det", v), pre_det, 0);
    end

    // R10: idle cycles with changing bit_in leave history alone
    do_reset();
    pair_thr = 8'd2;
    pd_irq_en = 1'b1;
    freq_lock_en = 1'b0;
    gain_lock_en = 1'b0;
    send_bit(1'b0);
    idle(3, 1'b0);
    idle(2, 1'b1);
    idle(1, 1'b0);
    send_bit(1'b1);
    check("R10", "pair across idle, no det yet", pre_det, 0);
    idle(2, 1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    check("R10", "second pair detects", pre_det, 1);
    check("R10", "irq with det", pre_irq, 1);

    // R9: handoff blocks detection until sync timeout, timeout clears history
    do_reset();
    pair_thr = 8'd1;
    send_bit(1'b0);
    send_bit(1'b1);
    check("R9", "initial det", pre_det, 1);
    send_bit(1'b1);
    check("R9", "end flagged", pre_end, 1);
    send_bit(1'b0);
    send_bit(1'b1);
    check("R9", "no det in handoff", pre_det, 0);
    send_bit(1'b0);
    pulse_timeout();
    send_bit(1'b1);
    check("R9", "history cleared by timeout", pre_det, 0);
    send_bit(1'b0);
    send_bit(1'b1);
    check("R9", "det after re-arm", pre_det, 1);

    // R9: timeout while hunting is ignored
    do_reset();
    pair_thr = 8'd2;
    send_bit(1'b0);
    send_bit(1'b1);
    pulse_timeout();
    send_bit(1'b0);
    send_bit(1'b1);
    check("R9", "hunt-time timeout ignored", pre_det, 1);

    // R7: lock strobes drop after one cycle
    freq_lock_en = 1'b1;
    gain_lock_en = 1'b1;
    do_reset();
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    check("R7", "locks high on det", {30'd0, freq_lock, gain_lock}, 32'd3);
    idle(1, 1'b0);
    check("R7", "locks low after one cycle", {30'd0, freq_lock, gain_lock}, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule